// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits on a small 16-bit register port. Its control word holds a run bit, a reset-on-expiry bit and an exponent. The exponent sets the timeout to a power of two of timer ticks. Timer ticks come from a parameterised prescaler on the block clock. Software cannot change the control word with a single store. It must first write two fixed unlock words to the control address, and the very next control-address write then becomes the new control word. To restart the count, software writes a different pair of fixed words to the same address, back to back.

When the count runs out with reset-on-expiry set, the block raises a one-cycle reset request and sets a sticky flag. The flag records that the watchdog caused the reset. The system reset input returns everything else to the disarmed state but leaves that flag alone. Only power-on reset clears it, or a write-one-to-clear store from software. When the count runs out with reset-on-expiry clear, the block only raises a readable expired flag and starts counting again. A separate echo-enable register bit, while set, makes the control address deaf to all writes.

Top module: `kwdt_top`

## Requirements
- R1: After power-on reset the control word (address 0) reads 0x401E: run (bit 15) = 0, reset-on-expiry (bit 14) = 1, exponent (bits 4:0) = 30. Status (address 1) reads 0, and `rst_req` is low.
- R2: A control-address write that does not directly follow the unlock pair 0x3333 then 0xCCCC leaves the control word unchanged.
- R3: After the unlock pair, the next control-address write is stored: bit 15 goes to run, bit 14 goes to reset-on-expiry, and bits 4:0 go to the exponent.
- R4: Any control-address write that does not continue the pending key sequence cancels that sequence. A key word (0x3333, 0xCCCC, 0xAAAA, 0x5555) written where a control value is expected is handled as a key and is never stored.
- R5: An exponent above 30 written through the unlock path is stored as 30.
- R6: While run is 0 the counter stays at zero, and no expiry, `rst_req` or status flag results.
- R7: With run = 1 and reset-on-expiry = 1, `rst_req` is high for exactly one cycle. That cycle follows the clock edge that lies PRE_DIV·2^exp cycles after the edge that stored the control word or restarted the count. Status bit 0 (watchdog reset) is then set.
- R8: Status bits are write-one-to-clear: writing 1 to bit 0 or bit 1 of address 1 clears that bit, and writing 0 leaves it unchanged.
- R9: A low `sys_rst_n` returns the control word to 0x401E and clears the echo bit and the expired flag. It does not change status bit 0.
- R10: Writing 0xAAAA then 0x5555 to the control address restarts the count, so the next expiry comes PRE_DIV·2^exp cycles after the second write.
- R11: A reset key pair broken by another control-address write does not restart the count.
- R12: While the echo bit (address 2, bit 0) is 1, control-address writes are ignored, including key words. Clearing the bit makes the unlock path work again.
- R13: With run = 1 and reset-on-expiry = 0, expiry sets status bit 1 (expired) and never raises `rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears all state |
| sys_rst_n | input | 1 | System reset, synchronous, active low; keeps the watchdog-reset flag |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 echo enable |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle system reset request on armed expiry |

## Verification
Control-address write patterns are driven in several forms: a bare value, a complete unlock pair plus value, a pair broken by a foreign word, and a key word landing in the value slot. Each form separates a correct sequencer from one that stores too eagerly or forgets to cancel. Expiry is timed to the exact cycle in three cases: straight from configuration, after a valid kick, and after a broken kick. Comparing those three shows whether the restart path fires exactly when it should. Armed and unarmed expiry are each followed by a system reset and by write-one-to-clear stores, which tells the sticky flag apart from the ordinary expired flag.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 2;
  localparam int EXP_W     = 5;
  localparam int EXP_MAX   = 30;
  localparam int RUN_BIT   = 15;
  localparam int RSTEN_BIT = 14;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_ECHO = 2'd2;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_OPEN,
    SEQ_KICK1
  } seq_e;

  typedef struct packed {
    logic             run;
    logic             rst_en;
    logic [EXP_W-1:0] expo;
  } ctrl_t;

  localparam ctrl_t CTRL_DISARMED = '{run: 1'b0, rst_en: 1'b1, expo: EXP_W'(EXP_MAX)};
endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNL_A  = 16'h3333,
  parameter logic [DATA_W-1:0] UNL_B  = 16'hCCCC,
  parameter logic [DATA_W-1:0] KICK_A = 16'hAAAA,
  parameter logic [DATA_W-1:0] KICK_B = 16'h5555
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output seq_e              seq_q,
  output logic              kick,
  output logic              load
);
  seq_e             seq_d;
  ctrl_t            ctrl_d;
  logic             is_key;
  logic [EXP_W-1:0] exp_in;
  logic [EXP_W-1:0] exp_sat;

  assign is_key  = (wdata == UNL_A) || (wdata == UNL_B) ||
                   (wdata == KICK_A) || (wdata == KICK_B);
  assign exp_in  = wdata[EXP_W-1:0];
  assign exp_sat = (exp_in > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_in;

  always_comb begin
    seq_d  = seq_q;
    ctrl_d = ctrl_q;
    kick   = 1'b0;
    load   = 1'b0;
    if (!sys_rst_n) begin
      seq_d  = SEQ_IDLE;
      ctrl_d = CTRL_DISARMED;
    end else if (ctl_wr) begin
      if (seq_q == SEQ_OPEN && !is_key) begin
        ctrl_d.run    = wdata[RUN_BIT];
        ctrl_d.rst_en = wdata[RSTEN_BIT];
        ctrl_d.expo   = exp_sat;
        load          = 1'b1;
        seq_d         = SEQ_IDLE;
      end else if (wdata == UNL_A) begin
        seq_d = SEQ_UNL1;
      end else if (wdata == KICK_A) begin
        seq_d = SEQ_KICK1;
      end else if (wdata == UNL_B && seq_q == SEQ_UNL1) begin
        seq_d = SEQ_OPEN;
      end else if (wdata == KICK_B && seq_q == SEQ_KICK1) begin
        kick  = 1'b1;
        seq_d = SEQ_IDLE;
      end else begin
        seq_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seq_q  <= SEQ_IDLE;
      ctrl_q <= CTRL_DISARMED;
    end else begin
      seq_q  <= seq_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/kwdt_timer.sv
module kwdt_timer
  import kwdt_pkg::*;
#(
  parameter int PRE_DIV = 1024,
  parameter int CNT_W   = EXP_MAX
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic             run,
  input  logic [EXP_W-1:0] expo,
  output logic [CNT_W-1:0] cnt_q,
  output logic             exp_q
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic             tick;
  logic [CNT_W-1:0] cnt_d;
  logic             exp_d;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   term;
  logic             hit;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      logic [PRE_W-1:0] pre_d;

      assign tick = run && (pre_q == PRE_W'(PRE_DIV - 1));

      always_comb begin
        if (clr || !run || tick) pre_d = '0;
        else                     pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_nopre
      assign tick = run;
    end
  endgenerate

  assign span = (CNT_W+1)'(1) << expo;
  assign term = span - 1'b1;
  assign hit  = tick && (cnt_q == term[CNT_W-1:0]);

  always_comb begin
    exp_d = 1'b0;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      exp_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/kwdt_status.sv
module kwdt_status (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       exp_pulse,
  input  logic       rst_en,
  input  logic       stat_wr,
  input  logic [1:0] clr_mask,
  output logic       rst_req,
  output logic       sticky_q,
  output logic       expired_q
);
  logic sticky_d;
  logic expired_d;

  assign rst_req = exp_pulse && rst_en;

  always_comb begin
    sticky_d  = sticky_q;
    expired_d = expired_q;
    if (!sys_rst_n) begin
      expired_d = 1'b0;
    end else if (stat_wr) begin
      if (clr_mask[0]) sticky_d  = 1'b0;
      if (clr_mask[1]) expired_d = 1'b0;
    end
    if (rst_req)                           sticky_d  = 1'b1;
    if (sys_rst_n && exp_pulse && !rst_en) expired_d = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sticky_q  <= 1'b0;
      expired_q <= 1'b0;
    end else begin
      sticky_q  <= sticky_d;
      expired_q <= expired_d;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int                PRE_DIV = 1024,
  parameter logic [DATA_W-1:0] UNL_A   = 16'h3333,
  parameter logic [DATA_W-1:0] UNL_B   = 16'hCCCC,
  parameter logic [DATA_W-1:0] KICK_A  = 16'hAAAA,
  parameter logic [DATA_W-1:0] KICK_B  = 16'h5555
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);
  localparam int CNT_W = EXP_MAX;
  localparam int PAD_W = DATA_W - 2 - EXP_W;

  logic             echo_q;
  logic             echo_d;
  logic             ctl_wr;
  logic             stat_wr;
  ctrl_t            ctrl_q;
  seq_e             seq_q;
  logic             kick;
  logic             load;
  logic             tmr_clr;
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             sticky_q;
  logic             expired_q;

  assign ctl_wr  = wr_en && (addr == A_CTRL) && !echo_q;
  assign stat_wr = wr_en && (addr == A_STAT);
  assign tmr_clr = kick || load || !sys_rst_n;

  always_comb begin
    echo_d = echo_q;
    if (!sys_rst_n)                       echo_d = 1'b0;
    else if (wr_en && (addr == A_ECHO))   echo_d = wdata[0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) echo_q <= 1'b0;
    else        echo_q <= echo_d;
  end

  kwdt_keyseq #(
    .UNL_A (UNL_A),
    .UNL_B (UNL_B),
    .KICK_A(KICK_A),
    .KICK_B(KICK_B)
  ) u_seq (
    .clk      (clk),
    .por_n    (por_n),
    .sys_rst_n(sys_rst_n),
    .ctl_wr   (ctl_wr),
    .wdata    (wdata),
    .ctrl_q   (ctrl_q),
    .seq_q    (seq_q),
    .kick     (kick),
    .load     (load)
  );

  kwdt_timer #(
    .PRE_DIV(PRE_DIV),
    .CNT_W  (CNT_W)
  ) u_tmr (
    .clk  (clk),
    .por_n(por_n),
    .clr  (tmr_clr),
    .run  (ctrl_q.run),
    .expo (ctrl_q.expo),
    .cnt_q(cnt_q),
    .exp_q(exp_q)
  );

  kwdt_status u_stat (
    .clk      (clk),
    .por_n    (por_n),
    .sys_rst_n(sys_rst_n),
    .exp_pulse(exp_q),
    .rst_en   (ctrl_q.rst_en),
    .stat_wr  (stat_wr),
    .clr_mask (wdata[1:0]),
    .rst_req  (rst_req),
    .sticky_q (sticky_q),
    .expired_q(expired_q)
  );

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {ctrl_q.run, ctrl_q.rst_en, {PAD_W{1'b0}}, ctrl_q.expo};
      A_STAT:  rdata = {{(DATA_W-2){1'b0}}, expired_q, sticky_q};
      A_ECHO:  rdata = {{(DATA_W-1){1'b0}}, echo_q};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int CNT_W = EXP_MAX
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              echo_q,
  input ctrl_t             ctrl_q,
  input seq_e              seq_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              rst_req,
  input logic              sticky_q
);
  // R6: a disarmed timer holds its count at zero
  a_r6_idle_disarmed: assert property (@(posedge clk) disable iff (!por_n)
    !ctrl_q.run |=> (cnt_q == '0));

  // R7: a reset request only comes from an armed, reset-enabled timer
  a_r7_req_armed: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> (ctrl_q.run && ctrl_q.rst_en));

  // R7: the sticky flag rises only after a reset request
  a_r7_sticky_source: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sticky_q) |-> $past(rst_req));

  // R9: system reset does not clear the sticky flag
  a_r9_sticky_kept: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && sticky_q) |=> sticky_q);

  // R4: the control word changes only out of the open state or by system reset
  a_r4_ctrl_gate: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_q != $past(ctrl_q)) |-> (($past(seq_q) == SEQ_OPEN) || !$past(sys_rst_n)));

  // R12: with echo set a control write moves neither the word nor the sequencer
  a_r12_echo_freeze: assert property (@(posedge clk) disable iff (!por_n)
    (echo_q && wr_en && (addr == A_CTRL) && sys_rst_n) |=> ($stable(ctrl_q) && $stable(seq_q)));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .sys_rst_n(sys_rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .echo_q   (echo_q),
  .ctrl_q   (ctrl_q),
  .seq_q    (seq_q),
  .cnt_q    (cnt_q),
  .rst_req  (rst_req),
  .sticky_q (sticky_q)
);

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
  localparam int P = 3;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        rst_req;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic [15:0] q_exp[$];
  bit          q_pin[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  kwdt_top #(.PRE_DIV(P)) u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_tag.size() > 0) begin
        logic [15:0] e;
        logic [15:0] act;
        bit          pin;
        string       t;
        pin = q_pin.pop_front();
        e   = q_exp.pop_front();
        t   = q_tag.pop_front();
        act = pin ? {15'h0, rst_req} : rdata;
        n_chk++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    addr = a;
    q_pin.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic chk_pin(input logic e, input string t);
    q_pin.push_back(1'b1); q_exp.push_back({15'h0, e}); q_tag.push_back(t);
  endtask

  task automatic unlock_wr(input logic [15:0] d);
    wr(2'd0, 16'h3333);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, d);
  endtask

  task automatic sysrst();
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
  endtask

  // expects rst_req exactly 'cyc' edges after the last write edge, for one cycle
  task automatic expect_fire(input int cyc, input string t);
    for (int k = 1; k < cyc; k++) begin
      @(negedge clk); chk_pin(1'b0, t);
    end
    @(negedge clk); chk_pin(1'b1, t);
    @(negedge clk); chk_pin(1'b0, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R1 reset state
    chk_rd(2'd0, 16'h401E, "R1 ctrl reset");
    chk_rd(2'd1, 16'h0000, "R1 status reset");
    @(negedge clk); chk_pin(1'b0, "R1 rst_req reset");

    // R2 bare write ignored
    wr(2'd0, 16'h8003);
    chk_rd(2'd0, 16'h401E, "R2 bare write");

    // R3 unlock then value
    unlock_wr(16'h0005);
    chk_rd(2'd0, 16'h0005, "R3 unlocked write");

    // R4 broken unlock, then key word in value slot
    wr(2'd0, 16'h3333); wr(2'd0, 16'h1234); wr(2'd0, 16'hCCCC); wr(2'd0, 16'h0007);
    chk_rd(2'd0, 16'h0005, "R4 broken unlock");
    unlock_wr(16'hAAAA);
    wr(2'd0, 16'h5555);
    chk_rd(2'd0, 16'h0005, "R4 key not stored");

    // R5 exponent saturation
    unlock_wr(16'h001F);
    chk_rd(2'd0, 16'h001E, "R5 exp saturate");

    // R6 disarmed: no counting
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); chk_pin(1'b0, "R6 disarmed no req");
    end
    chk_rd(2'd1, 16'h0000, "R6 disarmed no flag");

    // R7 armed expiry, exp 3 -> 8 ticks * P
    unlock_wr(16'hC003);
    expect_fire(8 * P, "R7 armed expiry");
    chk_rd(2'd1, 16'h0001, "R7 sticky set");

    // R9 system reset keeps sticky, restores ctrl
    sysrst();
    chk_rd(2'd1, 16'h0001, "R9 sticky kept");
    chk_rd(2'd0, 16'h401E, "R9 ctrl default");

    // R8 write-one-to-clear
    wr(2'd1, 16'h0000);
    chk_rd(2'd1, 16'h0001, "R8 write zero no effect");
    wr(2'd1, 16'h0001);
    chk_rd(2'd1, 16'h0000, "R8 w1c clears");

    // R10 kick restarts the count, exp 2 -> 4 ticks * P
    unlock_wr(16'hC002);
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h5555);
    expect_fire(4 * P, "R10 kick restart");
    sysrst();

    // R11 broken kick does not restart
    unlock_wr(16'hC002);
    wr(2'd0, 16'hAAAA);
    wr(2'd0, 16'h1234);
    wr(2'd0, 16'h5555);
    expect_fire(4 * P - 6, "R11 broken kick");
    sysrst();
    wr(2'd1, 16'h0003);

    // R12 echo blocks control writes
    wr(2'd2, 16'h0001);
    chk_rd(2'd2, 16'h0001, "R12 echo readback");
    unlock_wr(16'h0004);
    chk_rd(2'd0, 16'h401E, "R12 blocked by echo");
    wr(2'd2, 16'h0000);
    unlock_wr(16'h0004);
    chk_rd(2'd0, 16'h0004, "R12 echo cleared");

    // R13 unarmed-reset expiry sets expired flag only
    unlock_wr(16'h8002);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); chk_pin(1'b0, "R13 no rst_req");
    end
    chk_rd(2'd1, 16'h0002, "R13 expired flag");
    sysrst();
    chk_rd(2'd1, 16'h0000, "R9 expired cleared by sys reset");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule